// File: doc/BRIEF.md
# Edge-Triggered Input Capture Unit

This block timestamps external events. Each capture channel watches one input pin. When the selected transition appears on that pin, the channel copies a free-running 16-bit time value, supplied from outside the block, into its own capture register. The same event raises the channel's event flag. The interrupt line is high while any flag is set and its enable bit is also set. Software measures a period or a pulse width by subtracting two captured timestamps. The block does not count time itself.

Each pin first passes through a two-flop synchronizer. After that, a two-state level tracker (states `LVL_LOW` and `LVL_HIGH`) follows the synchronized level. Transition `LVL_LOW -> LVL_HIGH` is a rising event and transition `LVL_HIGH -> LVL_LOW` is a falling event. Each channel has a 2-bit field that decides which of these events cause a capture. The tracker follows the pin even while capture is disabled. Because of this, changing the field never produces a false event.

The last channel can also act as an output compare. A mode bit makes the choice. With the mode bit at 1, the last channel is an ordinary capture channel. With the mode bit at 0, its pin is ignored and its register holds a compare value that software writes. The flag of that channel is set when the time value equals the compare value.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. The level trackers start in `LVL_LOW`.
- R2: Channel n has a select field at control bits [2n+1:2n]. Bit 2n enables rising-edge capture and bit 2n+1 enables falling-edge capture. So 00 disables the channel, 01 selects rising edges, 10 selects falling edges and 11 selects both. An edge of a kind that is not selected leaves the register and the flag unchanged.
- R3: A pin change is seen after the two synchronizer flops. The capture register takes the `ts_in` value present at the third rising clock edge after the pin change.
- R4: The clock edge that writes a capture also sets the channel's flag. `irq` is high exactly when a flag is set and the matching bit of the mask register (address 5, bit n) is also set.
- R5: A write to the flag register (address 6) clears each flag whose data bit is 1 and leaves the others unchanged. If a new event and a clear hit the same flag in the same cycle, the flag stays set.
- R6: A new selected edge overwrites the capture register even when the flag is still set.
- R7: Reading never changes any register. Writes to capture addresses are ignored for channels 0 to 2, and for the last channel while it is in capture mode.
- R8: Control bit 8 is the mode bit. When it is 1, the last channel captures. When it is 0, pin edges on the last channel are ignored, address 3 can be written with a compare value, and flag 3 is set one cycle after `ts_in` equals that value.
- R9: The address map is: 0 to 3 are the capture registers, 4 is control, 5 is mask, 6 is flags, and 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ts_in | input | 16 | Free-running time value |
| cap_pin | input | 4 | Asynchronous event pins, one per channel |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
A level tracker that disagrees with the pin would show up as a capture on an edge that was not selected, or as a missing capture. This can be read back at the flag register three cycles after the pin change. A capture register loaded one cycle early or late holds a timestamp that is off by exactly one. Every edge check compares the captured value with the exact time value. A flag that clears without a write, or that loses a same-cycle event, shows on `irq` and at address 6 on the next cycle.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_t;

    localparam int unsigned ADDR_W    = 3;
    localparam logic [2:0]  A_CTRL    = 3'd4;
    localparam logic [2:0]  A_MASK    = 3'd5;
    localparam logic [2:0]  A_FLAG    = 3'd6;
endpackage

// File: rtl/ecu_sync.sv
module ecu_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ecu_channel.sv
module ecu_channel
    import ecu_pkg::*;
#(
    parameter int unsigned TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_s,
    input  logic [1:0]      sel,
    input  logic            cap_en,
    input  logic [TS_W-1:0] ts,
    input  logic            load_we,
    input  logic [TS_W-1:0] load_data,
    output logic            hit,
    output logic [TS_W-1:0] cap_q
);
    lvl_t state_q, state_d;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        fall    = 1'b0;
        unique case (state_q)
            LVL_LOW:  if (pin_s)  begin state_d = LVL_HIGH; rise = 1'b1; end
            LVL_HIGH: if (!pin_s) begin state_d = LVL_LOW;  fall = 1'b1; end
        endcase
    end

    assign hit = cap_en && ((rise && sel[0]) || (fall && sel[1]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cap_q <= '0;
        else if (hit)     cap_q <= ts;
        else if (load_we) cap_q <= load_data;
    end

    assert_capture_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cap_q == $past(ts));

    assert_disabled_field_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00 && !load_we) |=> $stable(cap_q));
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import ecu_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned TS_W   = 16,
    parameter int unsigned SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   ts_in,
    input  logic [NUM_CH-1:0] cap_pin,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [TS_W-1:0]   bus_wdata,
    output logic [TS_W-1:0]   bus_rdata,
    output logic              irq
);
    localparam int unsigned SEL_W    = 2 * NUM_CH;
    localparam int unsigned MODE_BIT = 8;
    localparam int unsigned LAST     = NUM_CH - 1;

    logic [SEL_W-1:0]  sel_q;
    logic              mode_q;
    logic [NUM_CH-1:0] mask_q, flag_q, hit, pin_s, ev;
    logic [TS_W-1:0]   cap [NUM_CH];
    logic              cmp_hit;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            logic ch_en, ch_we;
            ecu_sync #(.STAGES(SYNC_N)) u_sync (
                .clk(clk), .rst_n(rst_n), .d_async(cap_pin[g]), .q_sync(pin_s[g]));
            if (g == LAST) begin : g_shared
                assign ch_en = mode_q;
                assign ch_we = bus_wr && (bus_addr == ADDR_W'(g)) && !mode_q;
            end else begin : g_plain
                assign ch_en = 1'b1;
                assign ch_we = 1'b0;
            end
            ecu_channel #(.TS_W(TS_W)) u_chan (
                .clk(clk), .rst_n(rst_n), .pin_s(pin_s[g]),
                .sel(sel_q[2*g+1 -: 2]), .cap_en(ch_en), .ts(ts_in),
                .load_we(ch_we), .load_data(bus_wdata),
                .hit(hit[g]), .cap_q(cap[g]));
        end
    endgenerate

    assign cmp_hit = !mode_q && (ts_in == cap[LAST]);

    always_comb begin
        ev       = hit;
        ev[LAST] = hit[LAST] | cmp_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            mode_q <= 1'b0;
            mask_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL) begin
                sel_q  <= bus_wdata[SEL_W-1:0];
                mode_q <= bus_wdata[MODE_BIT];
            end
            if (bus_addr == A_MASK) mask_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ev[i])
                    flag_q[i] <= 1'b1;
                else if (bus_wr && bus_addr == A_FLAG && bus_wdata[i])
                    flag_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[SEL_W-1:0] = sel_q;
                bus_rdata[MODE_BIT]  = mode_q;
            end
            A_MASK: bus_rdata[NUM_CH-1:0] = mask_q;
            A_FLAG: bus_rdata[NUM_CH-1:0] = flag_q;
            default: begin
                for (int i = 0; i < NUM_CH; i++)
                    if (bus_addr == ADDR_W'(i)) bus_rdata = cap[i];
            end
        endcase
    end

    assign irq = |(flag_q & mask_q);

    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chk
            assert_hit_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
                ev[g] |=> flag_q[g]);
            assert_flag_clear_needs_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(flag_q[g]) |-> $past(bus_wr && bus_addr == A_FLAG && bus_wdata[g]));
        end
    endgenerate

    assert_compare_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && ts_in == cap[LAST]) |=> flag_q[LAST]);
    assert_irq_needs_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));
endmodule

// File: tb/edge_capture_unit_bench.sv
module edge_capture_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ts_in = 16'h0100;
    logic [3:0]  cap_pin = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;
    logic [7:0]  sel_m = '0;
    logic        mode_m = 1'b1;
    logic [15:0] expv;

    edge_capture_unit u_edge_capture_unit (
        .clk(clk), .rst_n(rst_n), .ts_in(ts_in), .cap_pin(cap_pin),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq));

    always #4 clk = ~clk;
    always @(negedge clk) ts_in <= ts_in + 16'd1;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            finish_run();
        end
    end

    function automatic bit exp_hit(input logic [1:0] s, input logic oldv, input logic newv);
        return (!oldv && newv && s[0]) || (oldv && !newv && s[1]);
    endfunction

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic set_ctrl();
        wr(3'd4, {7'd0, mode_m, sel_m});
    endtask

    // drive pin ch to v at a falling edge; returns timestamp seen at 3rd rising edge
    task automatic drive(input int ch, input logic v, output logic [15:0] stamp);
        cap_pin[ch] = v;
        repeat (2) @(posedge clk);
        @(negedge clk); #1 stamp = ts_in;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        logic [15:0] r, st, prev;
        logic [15:0] capm [4];
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R9 map
        for (int a = 0; a < 8; a++) begin rd(3'(a), r); check("R1 reset", r, 16'h0); end
        check("R1 irq", {15'd0, irq}, 16'h0);

        // R2/R3 ch0 rising
        sel_m[1:0] = 2'b01; set_ctrl();
        drive(0, 1'b1, st);
        rd(3'd0, r); check("R3 ch0 rise stamp", r, st);
        rd(3'd6, r); check("R4 ch0 flag", r, 16'h1);
        check("R4 irq masked", {15'd0, irq}, 16'h0);
        prev = st;
        drive(0, 1'b0, st);
        rd(3'd0, r); check("R2 fall ignored on rise-only", r, prev);
        // R7 reads do not change, writes ignored
        wr(3'd0, 16'hBEEF); rd(3'd0, r); check("R7 cap0 write ignored", r, prev);
        rd(3'd0, r); check("R7 reread", r, prev);
        // R4 mask, R5 clear
        wr(3'd5, 16'h1); check("R4 irq on", {15'd0, irq}, 16'h1);
        wr(3'd6, 16'h0); rd(3'd6, r); check("R5 zero write keeps", r, 16'h1);
        wr(3'd6, 16'h1); rd(3'd6, r); check("R5 w1c", r, 16'h0);
        check("R4 irq off", {15'd0, irq}, 16'h0);

        // R2 ch1 falling
        sel_m[3:2] = 2'b10; set_ctrl();
        drive(1, 1'b1, st); rd(3'd6, r); check("R2 rise ignored ch1", r, 16'h0);
        drive(1, 1'b0, st); rd(3'd1, r); check("R2 ch1 fall stamp", r, st);
        // R6 overwrite with flag set
        drive(1, 1'b1, prev);
        drive(1, 1'b0, st); rd(3'd1, r); check("R6 overwrite", r, st);
        wr(3'd6, 16'hF);

        // R2 ch2 both
        sel_m[5:4] = 2'b11; set_ctrl();
        drive(2, 1'b1, st); rd(3'd2, r); check("R2 both rise", r, st);
        drive(2, 1'b0, st); rd(3'd2, r); check("R2 both fall", r, st);
        // R2 00 disables
        sel_m[5:4] = 2'b00; set_ctrl(); wr(3'd6, 16'hF);
        prev = st;
        drive(2, 1'b1, st); rd(3'd2, r); check("R2 disabled cap", r, prev);
        rd(3'd6, r); check("R2 disabled flag", r, 16'h0);

        // R5 set beats clear in the same cycle
        sel_m[1:0] = 2'b01; set_ctrl();
        cap_pin[0] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 16'h1;
        @(posedge clk); @(negedge clk); bus_wr = 1'b0;
        rd(3'd6, r); check("R5 set wins", r, 16'h1);
        wr(3'd6, 16'hF);

        // R8 last channel capture mode
        mode_m = 1'b1; sel_m[7:6] = 2'b01; set_ctrl();
        drive(3, 1'b1, st); rd(3'd3, r); check("R8 ch3 capture", r, st);
        wr(3'd3, 16'h1234); rd(3'd3, r); check("R7 ch3 write ignored", r, st);
        wr(3'd6, 16'hF);
        // R8 compare mode
        mode_m = 1'b0; set_ctrl();
        rd(3'd4, r); check("R9 ctrl readback", r, {7'd0, mode_m, sel_m});
        wr(3'd3, ts_in + 16'd20);
        rd(3'd3, r); expv = r;
        drive(3, 1'b0, st); drive(3, 1'b1, st);
        rd(3'd6, r); check("R8 pin ignored before match", r, 16'h0);
        rd(3'd3, r); check("R8 compare held", r, expv);
        repeat (25) @(negedge clk);
        rd(3'd6, r); check("R8 compare flag", r, 16'h8);
        rd(3'd7, r); check("R9 addr7 zero", r, 16'h0);
        wr(3'd6, 16'hF);

        // random stimulus on channels 0..2
        mode_m = 1'b1; set_ctrl();
        for (int k = 0; k < 4; k++) begin rd(3'(k), r); capm[k] = r; end
        for (int it = 0; it < 60; it++) begin
            int ch;
            logic [1:0] s;
            logic oldv;
            bit h;
            ch = int'($urandom % 3);
            s = 2'($urandom);
            sel_m[2*ch +: 2] = s; set_ctrl();
            oldv = cap_pin[ch];
            drive(ch, ~oldv, st);
            h = exp_hit(s, oldv, ~oldv);
            if (h) capm[ch] = st;
            rd(3'(ch), r); check("R2 random cap", r, capm[ch]);
            rd(3'd6, r); check("R4 random flag", r, h ? (16'h1 << ch) : 16'h0);
            wr(3'd6, 16'hF);
        end
        finish_run();
    end
endmodule